// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write an external asynchronous static RAM of 128K words by 8 bits. On the user side it offers a request/ready handshake. A request carries a 17-bit address, an 8-bit write word and a read/write select. A read returns its data on an 8-bit output together with a single-cycle valid strobe.

On the memory side the block drives the active-low chip, write and output enables and the address lines. The bidirectional data bus is split into an outgoing word, an incoming word and a driver enable, which the pad ring combines into a tristate pin.

The memory's timing figures are given to the block as parameters in picoseconds, along with the clock period. The block rounds each one up to a whole number of clock cycles, with a minimum of one cycle. A read holds the chip and output enables low for the access time and registers the word on the last access cycle. A write does three things in order:

- it drives the data one cycle before write enable falls;
- it holds write enable low for the pulse width;
- it keeps the address and data steady for one more cycle after write enable rises, which is the edge where the memory stores the word.

When a write is the first access after a read, the block inserts one dead cycle so the data bus can change direction. With no work to do, the block idles with every strobe high, which puts the memory in standby.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and right after it, all three memory strobes are high, the data driver enable is low, req_ready is high and rd_valid is low.
- R2: req_ready is high only when no access is in progress. Whenever req_ready is high, all strobes are high and the data driver is off.
- R3: A read accepted on a clock edge holds chip enable and output enable low, with write enable high, for exactly ACC cycles starting the next cycle. ACC is max(tAA, tOE) divided by the clock period, rounded up, and at least 1.
- R4: The read word is sampled from the data-in bus on the last access cycle. It appears on rd_data with rd_valid high for exactly one cycle, the cycle right after the access cycles. During that cycle output enable is already high.
- R5: A write runs in this order. First a setup cycle: chip enable low, write enable high, driver on with the request's data. Then write enable low for WP cycles, where WP is tWP divided by the clock period, rounded up, and at least 1. Then a hold cycle: write enable high, chip enable low, address and data unchanged. Then idle.
- R6: The data driver is never on while output enable is low and write enable is high.
- R7: A write that is the first access after a read is preceded by one cycle with all strobes high and the driver off. A write that follows a write, or that comes first after reset, has no such cycle.
- R8: Address and write data are captured when the request is accepted. Changes on the request inputs during an access have no effect on the memory bus or on the data stored.
- R9: rd_valid is never raised by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Word to write |
| rd_data | output | 8 | Word returned by a read |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 17 | Memory address lines |
| sram_dq_out | output | 8 | Word driven onto the data bus |
| sram_dq_in | input | 8 | Word seen on the data bus |
| sram_dq_oe | output | 1 | Data bus driver enable, active high |

## Verification
The bench sets the memory's access and pulse times so that they round up to three and two cycles. An off-by-one in a cycle counter therefore shows up as a read returning a word early or late, or as a write pulse that is too short. Writes are placed straight after reads and straight after writes. A design that skipped the dead cycle, or inserted it every time, fails the cycle-by-cycle strobe checks. A memory model stores words only on the rising edge of write enable and flags any write made with the driver off. Request inputs are scrambled as soon as each request is accepted, so a design that passes them through instead of latching them would write or read the wrong word.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_CAPTURE = 3'd2,
    ST_TURN       = 3'd3,
    ST_WR_SETUP   = 3'd4,
    ST_WR_PULSE   = 3'd5,
    ST_WR_HOLD    = 3'd6
  } ctl_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
    logic ready;
  } pins_t;

  // Round a time up to whole clock cycles, never less than one.
  function automatic int unsigned cycles_for(int unsigned t_ps, int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  // Pin levels wanted while the controller sits in a given state.
  function automatic pins_t pins_for(ctl_state_e s);
    pins_t p;
    p.ce_n  = 1'b1;
    p.we_n  = 1'b1;
    p.oe_n  = 1'b1;
    p.dq_oe = 1'b0;
    p.ready = 1'b0;
    case (s)
      ST_IDLE:       p.ready = 1'b1;
      ST_RD_ACCESS:  begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
      ST_RD_CAPTURE: p.ce_n = 1'b0;
      ST_WR_SETUP:   begin p.ce_n = 1'b0; p.dq_oe = 1'b1; end
      ST_WR_PULSE:   begin p.ce_n = 1'b0; p.we_n = 1'b0; p.dq_oe = 1'b1; end
      ST_WR_HOLD:    begin p.ce_n = 1'b0; p.dq_oe = 1'b1; end
      default:       p.ready = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ACC_CYC = 1,
  parameter int unsigned WP_CYC  = 1,
  parameter int unsigned CNT_W   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output ctl_state_e state_o,
  output ctl_state_e next_o,
  output logic       accept_o,
  output logic       capture_o
);

  ctl_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             after_rd_q, after_rd_d;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign accept_o  = (state_q == ST_IDLE) && req_valid;
  assign capture_o = (state_q == ST_RD_ACCESS) && cnt_zero;
  assign state_o   = state_q;
  assign next_o    = state_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    after_rd_d = after_rd_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          after_rd_d = 1'b0;
          if (req_write) begin
            state_d = after_rd_q ? ST_TURN : ST_WR_SETUP;
          end else begin
            state_d = ST_RD_ACCESS;
            cnt_d   = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      ST_RD_ACCESS: begin
        if (cnt_zero) state_d = ST_RD_CAPTURE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_RD_CAPTURE: begin
        after_rd_d = 1'b1;
        state_d    = ST_IDLE;
      end
      ST_TURN:     state_d = ST_WR_SETUP;
      ST_WR_SETUP: begin
        state_d = ST_WR_PULSE;
        cnt_d   = CNT_W'(WP_CYC - 1);
      end
      ST_WR_PULSE: begin
        if (cnt_zero) state_d = ST_WR_HOLD;
        else          cnt_d   = cnt_q - 1'b1;
      end
      ST_WR_HOLD:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      after_rd_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      after_rd_q <= after_rd_d;
    end
  end

  assert_turn_then_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TURN) |=> (state_q == ST_WR_SETUP));

  assert_hold_then_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_HOLD) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sram_ctl_pins.sv
`timescale 1ns/1ps
module sram_ctl_pins
  import sram_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_state_e next_state,
  output pins_t      pins_o
);

  pins_t pins_q;

  // Registered from the next state so every pin is a flop output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= pins_for(ST_IDLE);
    else        pins_q <= pins_for(next_state);
  end

  assign pins_o = pins_q;

endmodule

// File: rtl/sram_ctl_datapath.sv
`timescale 1ns/1ps
module sram_ctl_datapath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= capture;
  end

  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_PS  = 20000,
  parameter int unsigned T_AA_PS = 15000,
  parameter int unsigned T_OE_PS = 6000,
  parameter int unsigned T_WP_PS = 15000,
  parameter int unsigned AW      = 17,
  parameter int unsigned DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          sram_ce_n,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  input  logic [DW-1:0] sram_dq_in,
  output logic          sram_dq_oe
);

  localparam int unsigned T_RD_PS = (T_AA_PS > T_OE_PS) ? T_AA_PS : T_OE_PS;
  localparam int unsigned ACC_CYC = cycles_for(T_RD_PS, CLK_PS);
  localparam int unsigned WP_CYC  = cycles_for(T_WP_PS, CLK_PS);
  localparam int unsigned CNT_MAX = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int unsigned CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  ctl_state_e state, next_state;
  logic       accept, capture;
  pins_t      pins;

  sram_ctl_fsm #(.ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .state_o   (state),
    .next_o    (next_state),
    .accept_o  (accept),
    .capture_o (capture)
  );

  sram_ctl_pins u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_state (next_state),
    .pins_o     (pins)
  );

  sram_ctl_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (sram_dq_in),
    .addr_o    (sram_addr),
    .wdata_o   (sram_dq_out),
    .rdata_o   (rd_data),
    .rvalid_o  (rd_valid)
  );

  assign sram_ce_n  = pins.ce_n;
  assign sram_we_n  = pins.we_n;
  assign sram_oe_n  = pins.oe_n;
  assign sram_dq_oe = pins.dq_oe;
  assign req_ready  = pins.ready;

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n || !sram_we_n));

  assert_ready_means_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  assert_valid_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

  assert_write_edge_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && sram_we_n && $past(!sram_we_n))
      |-> (sram_dq_oe && $stable(sram_dq_out) && $stable(sram_addr)));

  assert_addr_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

endmodule

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;

  localparam int CLK_PS  = 20000;
  localparam int T_AA_PS = 45000;
  localparam int T_OE_PS = 6000;
  localparam int T_WP_PS = 25000;

  function automatic int ceil_cyc(int t, int c);
    int n;
    n = (t + c - 1) / c;
    return (n < 1) ? 1 : n;
  endfunction

  localparam int ACC_EXP = ceil_cyc((T_AA_PS > T_OE_PS) ? T_AA_PS : T_OE_PS, CLK_PS);
  localparam int WP_EXP  = ceil_cyc(T_WP_PS, CLK_PS);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [16:0] sram_addr;
  logic [7:0]  sram_dq_out;
  logic [7:0]  sram_dq_in;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] shadow[int];
  logic [7:0] mem[int];
  int  mem_gen = 0;
  bit  prev_read = 1'b0;

  always #10 clk = ~clk;

  sram_ctl #(.CLK_PS(CLK_PS), .T_AA_PS(T_AA_PS), .T_OE_PS(T_OE_PS), .T_WP_PS(T_WP_PS)) u_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Memory model: drives only when selected for a read, stores on rising write enable.
  always @(sram_ce_n or sram_oe_n or sram_we_n or sram_addr or mem_gen) begin
    if (!sram_ce_n && !sram_oe_n && sram_we_n)
      sram_dq_in = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'h00;
    else
      sram_dq_in = 8'h00;
  end

  always @(posedge sram_we_n) begin
    if (rst_n && !sram_ce_n) begin
      chk(sram_dq_oe, "R5", "driver on at write edge", int'(sram_dq_oe), 1);
      mem[int'(sram_addr)] = sram_dq_out;
      mem_gen++;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sram_dq_oe)
        chk(sram_oe_n || !sram_we_n, "R6", "driver on while memory outputs", int'(sram_oe_n), 1);
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected rd_valid", 1, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R4", "read data", int'(rd_data), int'(e));
        end
      end
    end
  end

  task automatic do_req(bit wr, logic [16:0] a, logic [7:0] d);
    bit turn;
    int off;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    turn = wr && prev_read;
    off  = turn ? 1 : 0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[int'(a)] = d;
    else    exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    prev_read = !wr;
    @(posedge clk);
    if (!wr) begin
      for (int n = 1; n <= ACC_EXP + 1; n++) begin
        @(negedge clk);
        if (n == 1) begin req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; end
        if (n <= ACC_EXP) begin
          chk(!sram_ce_n && !sram_oe_n && sram_we_n, "R3", "read strobes",
              {sram_ce_n, sram_oe_n, sram_we_n}, 3'b001);
          chk(sram_addr == a, "R8", "read address held", int'(sram_addr), int'(a));
          chk(!req_ready, "R2", "ready during access", int'(req_ready), 0);
          chk(!rd_valid, "R4", "rd_valid early", int'(rd_valid), 0);
        end else begin
          chk(rd_valid, "R4", "rd_valid at latency", int'(rd_valid), 1);
          chk(sram_oe_n, "R4", "oe released in valid cycle", int'(sram_oe_n), 1);
        end
      end
    end else begin
      for (int n = 1; n <= off + WP_EXP + 2; n++) begin
        @(negedge clk);
        if (n == 1) begin req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; end
        chk(!rd_valid, "R9", "rd_valid in write", int'(rd_valid), 0);
        chk(!req_ready, "R2", "ready during write", int'(req_ready), 0);
        if (n <= off) begin
          chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R7", "turnaround cycle",
              {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);
        end else if (n == off + 1) begin
          chk(!sram_ce_n && sram_we_n && sram_dq_oe, "R5", "setup cycle",
              {sram_ce_n, sram_we_n, sram_dq_oe}, 3'b011);
          chk(sram_dq_out == d, "R8", "write data latched", int'(sram_dq_out), int'(d));
        end else if (n <= off + 1 + WP_EXP) begin
          chk(!sram_ce_n && !sram_we_n, "R5", "write pulse", {sram_ce_n, sram_we_n}, 2'b00);
          chk(sram_addr == a, "R8", "write address held", int'(sram_addr), int'(a));
        end else begin
          chk(!sram_ce_n && sram_we_n && sram_dq_oe && sram_dq_out == d && sram_addr == a,
              "R5", "hold cycle", int'(sram_dq_out), int'(d));
        end
      end
    end
  endtask

  initial begin
    logic [16:0] pool [5];
    pool[0] = 17'h00000; pool[1] = 17'h1FFFF; pool[2] = 17'h0AAAA;
    pool[3] = 17'h15555; pool[4] = 17'h10001;
    repeat (3) @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready && !rd_valid,
        "R1", "state in reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rd_valid}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready && !rd_valid,
        "R1", "state after reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready, rd_valid}, 6'b111010);

    do_req(1'b1, 17'h00123, 8'h5A);   // first write: no turnaround (R7)
    do_req(1'b0, 17'h00123, 8'h00);   // read back (R4)
    do_req(1'b0, 17'h1FFFF, 8'h00);   // untouched word reads zero
    do_req(1'b1, 17'h1FFFF, 8'hC3);   // write after read: turnaround (R7)
    do_req(1'b1, 17'h00000, 8'hFF);   // write after write: none
    do_req(1'b0, 17'h1FFFF, 8'h00);
    do_req(1'b0, 17'h00000, 8'h00);
    for (int i = 0; i < 40; i++)
      do_req((i % 3) != 1, pool[i % 5], 8'(i * 37 + 5));
    for (int i = 0; i < 5; i++) do_req(1'b0, pool[i], 8'h00);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all reads returned", exp_q.size(), 0);
    chk(sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && req_ready, "R2", "standby when idle",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready}, 5'b11101);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule